// File: doc/BRIEF.md
# Bus access comparator bank

This block watches each CPU bus cycle and reports, one clock later, which of three comparators recognised it. A bus cycle presents an address, a 16-bit data word, a read/write flag and a byte/word size flag, qualified by a valid strobe. Comparator A matches on address and on data, with a per-bit data mask. Comparators B and C match on address alone. Every comparator can be limited to one transfer direction. Comparator B, and only B, can also be limited to one access size.

A window mode joins A and B into one address interval check. A supplies the lower bound and B the upper bound. The interval test can be inside the bounds (both inclusive) or outside them. It is reported on A's output, and B's own output stays quiet. Each reported hit is also typed as tag-type or force-type for the state sequencer that consumes the outputs. Software programs the bank through a plain write port of select, data and write enable. The reset input is asserted asynchronously and must be released in step with the clock.

Top module: `bus_cmp_bank`

## Requirements
- R1: After reset every comparator is disabled, all reference values are zero, the window mode is simple, and `match_o` and `force_o` are zero. Any bus cycle seen in this state produces no hit.
- R2: A bus cycle sampled on a rising edge with `bus_valid`=1 shows its result on `match_o`/`force_o` after that edge, for exactly one cycle. A cycle with `bus_valid`=0 yields all-zero outputs. Back-to-back valid cycles each give their own result.
- R3: In simple mode, comparator A (bit 0) hits when the address equals its reference address and `(bus_data & mask) == (ref_data & mask)`. A mask bit of 1 takes part in the comparison and 0 ignores it.
- R4: Comparators B (bit 1) and C (bit 2) hit on address equality alone, whatever `bus_data` holds.
- R5: Control bit 1 enables the direction qualifier, and control bit 2 picks reads (1) or writes (0). `bus_rd`=1 marks a read. With bit 1 clear, both directions match.
- R6: On B only, control bit 4 enables the size qualifier, and control bit 5 picks word (1) or byte (0). `bus_word`=1 marks a word access. Size bits written to A or C have no effect.
- R7: Mode 1 (inside) makes bit 0 hit when `A_addr <= bus_addr <= B_addr`, with A's enable, direction and masked data qualifiers applied. Bit 1 is always 0 in this mode.
- R8: Mode 2 (outside) makes bit 0 hit when `bus_addr < A_addr` or `bus_addr > B_addr`, with A's qualifiers applied. Bit 1 is always 0 in this mode.
- R9: `force_o[i]` is 1 only when `match_o[i]` is 1 and control bit 3 of comparator i is set. Otherwise the hit is tag-type. In the window modes, A's bit 3 types the result.
- R10: Control bit 0 enables a comparator. When it is clear, that comparator never hits.
- R11: The write select map is: 0 A control, 1 A address, 2 A data, 3 A mask, 4 B control, 5 B address, 6 C control, 7 C address, 8 mode (bits 1:0). Selects 9 to 15 change nothing, and mode 3 behaves as simple.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration register select |
| cfg_wdata | input | ADDR_W | Configuration write data |
| bus_valid | input | 1 | Bus cycle present this clock |
| bus_addr | input | ADDR_W | Bus cycle address |
| bus_data | input | DATA_W | Bus cycle data |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_word | input | 1 | 1 = word access, 0 = byte access |
| match_o | output | 3 | Per-comparator hit pulse, bit 0 = A, 1 = B, 2 = C |
| force_o | output | 3 | Per-comparator hit type, 1 = force, 0 = tag |

## Verification
The bench builds the block with its default widths: an 18-bit address and 16-bit data. This puts the top of the address space, 0x3FFFF, and half-masked data words within reach of the directed cases. Window bounds are probed exactly at, one below and one above each edge, so off-by-one errors in the inclusive comparisons become visible. Mode 3 and unused select values are exercised to confirm that they fall back to simple matching and leave the programmed state intact.

// File: rtl/bcb_pkg.sv
package bcb_pkg;
  localparam int NUM_CMP = 3;
  localparam int SEL_W   = 4;

  // control word layout: bit0 enable, bit1 direction qualify, bit2 read select,
  // bit3 force type, bit4 size qualify, bit5 word select
  typedef struct packed {
    logic sz_word;
    logic sz_en;
    logic frc;
    logic dir_rd;
    logic dir_en;
    logic en;
  } cmp_ctrl_t;

  localparam int CTRL_W = $bits(cmp_ctrl_t);

  typedef enum logic [1:0] {
    MODE_SIMPLE  = 2'd0,
    MODE_INSIDE  = 2'd1,
    MODE_OUTSIDE = 2'd2,
    MODE_ALT     = 2'd3
  } win_mode_e;

  localparam logic [SEL_W-1:0] SEL_A_CTRL = 4'd0;
  localparam logic [SEL_W-1:0] SEL_A_ADDR = 4'd1;
  localparam logic [SEL_W-1:0] SEL_A_DATA = 4'd2;
  localparam logic [SEL_W-1:0] SEL_A_MASK = 4'd3;
  localparam logic [SEL_W-1:0] SEL_B_CTRL = 4'd4;
  localparam logic [SEL_W-1:0] SEL_B_ADDR = 4'd5;
  localparam logic [SEL_W-1:0] SEL_C_CTRL = 4'd6;
  localparam logic [SEL_W-1:0] SEL_C_ADDR = 4'd7;
  localparam logic [SEL_W-1:0] SEL_MODE   = 4'd8;
endpackage

// File: rtl/bcb_cfg_regs.sv
module bcb_cfg_regs
  import bcb_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [SEL_W-1:0]                  cfg_sel,
  input  logic [ADDR_W-1:0]                 cfg_wdata,
  output cmp_ctrl_t [NUM_CMP-1:0]           ctrl_o,
  output logic [NUM_CMP-1:0][ADDR_W-1:0]    addr_o,
  output logic [DATA_W-1:0]                 data_o,
  output logic [DATA_W-1:0]                 mask_o,
  output win_mode_e                         mode_o
);
  cmp_ctrl_t [NUM_CMP-1:0]        ctrl_q, ctrl_d;
  logic [NUM_CMP-1:0][ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0]              data_q, data_d, mask_q, mask_d;
  win_mode_e                      mode_q, mode_d;
  cmp_ctrl_t                      wr_ctrl;

  assign wr_ctrl = cmp_ctrl_t'(cfg_wdata[CTRL_W-1:0]);

  always_comb begin
    ctrl_d = ctrl_q;
    addr_d = addr_q;
    data_d = data_q;
    mask_d = mask_q;
    mode_d = mode_q;
    unique case (cfg_sel)
      SEL_A_CTRL: begin
        ctrl_d[0]         = wr_ctrl;
        ctrl_d[0].sz_en   = 1'b0;
        ctrl_d[0].sz_word = 1'b0;
      end
      SEL_A_ADDR: addr_d[0] = cfg_wdata;
      SEL_A_DATA: data_d    = cfg_wdata[DATA_W-1:0];
      SEL_A_MASK: mask_d    = cfg_wdata[DATA_W-1:0];
      SEL_B_CTRL: ctrl_d[1] = wr_ctrl;
      SEL_B_ADDR: addr_d[1] = cfg_wdata;
      SEL_C_CTRL: begin
        ctrl_d[2]         = wr_ctrl;
        ctrl_d[2].sz_en   = 1'b0;
        ctrl_d[2].sz_word = 1'b0;
      end
      SEL_C_ADDR: addr_d[2] = cfg_wdata;
      SEL_MODE:   mode_d    = win_mode_e'(cfg_wdata[1:0]);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      addr_q <= '0;
      data_q <= '0;
      mask_q <= '0;
      mode_q <= MODE_SIMPLE;
    end else if (cfg_we) begin
      ctrl_q <= ctrl_d;
      addr_q <= addr_d;
      data_q <= data_d;
      mask_q <= mask_d;
      mode_q <= mode_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign addr_o = addr_q;
  assign data_o = data_q;
  assign mask_o = mask_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/bcb_cmp_unit.sv
module bcb_cmp_unit
  import bcb_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 16,
  parameter bit HAS_DATA = 1'b0,
  parameter bit HAS_SIZE = 1'b0
) (
  input  cmp_ctrl_t          ctrl_i,
  input  logic [ADDR_W-1:0]  ref_addr_i,
  input  logic [DATA_W-1:0]  ref_data_i,
  input  logic [DATA_W-1:0]  ref_mask_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_data_i,
  input  logic               bus_rd_i,
  input  logic               bus_word_i,
  output logic               qual_o,
  output logic               addr_eq_o
);
  logic dir_ok, size_ok, data_ok;

  assign dir_ok = !ctrl_i.dir_en || (ctrl_i.dir_rd == bus_rd_i);

  if (HAS_DATA) begin : g_data
    assign data_ok = ((bus_data_i ^ ref_data_i) & ref_mask_i) == '0;
  end else begin : g_nodata
    logic unused_data;
    assign unused_data = ^{ref_data_i, ref_mask_i, bus_data_i};
    assign data_ok     = 1'b1;
  end

  if (HAS_SIZE) begin : g_size
    assign size_ok = !ctrl_i.sz_en || (ctrl_i.sz_word == bus_word_i);
  end else begin : g_nosize
    logic unused_size;
    assign unused_size = ^{ctrl_i.sz_en, ctrl_i.sz_word, bus_word_i};
    assign size_ok     = 1'b1;
  end

  assign qual_o    = ctrl_i.en && dir_ok && size_ok && data_ok;
  assign addr_eq_o = (bus_addr_i == ref_addr_i);
endmodule

// File: rtl/bus_cmp_bank.sv
module bus_cmp_bank
  import bcb_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_rd,
  input  logic              bus_word,
  output logic [2:0]        match_o,
  output logic [2:0]        force_o
);
  cmp_ctrl_t [NUM_CMP-1:0]        ctrl;
  logic [NUM_CMP-1:0][ADDR_W-1:0] caddr;
  logic [DATA_W-1:0]              a_data, a_mask;
  win_mode_e                      cfg_mode;
  logic [NUM_CMP-1:0]             qual, addr_eq, hit_d, kind_d, frc_bits;
  logic [NUM_CMP-1:0]             match_q, force_q;
  logic                           in_win;

  bcb_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .ctrl_o   (ctrl),
    .addr_o   (caddr),
    .data_o   (a_data),
    .mask_o   (a_mask),
    .mode_o   (cfg_mode)
  );

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    bcb_cmp_unit #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .HAS_DATA(i == 0),
      .HAS_SIZE(i == 1)
    ) u_unit (
      .ctrl_i    (ctrl[i]),
      .ref_addr_i(caddr[i]),
      .ref_data_i(a_data),
      .ref_mask_i(a_mask),
      .bus_addr_i(bus_addr),
      .bus_data_i(bus_data),
      .bus_rd_i  (bus_rd),
      .bus_word_i(bus_word),
      .qual_o    (qual[i]),
      .addr_eq_o (addr_eq[i])
    );
    assign frc_bits[i] = ctrl[i].frc;
  end

  // window: A holds the low bound, B the high bound, both inclusive
  assign in_win = (bus_addr >= caddr[0]) && (bus_addr <= caddr[1]);

  always_comb begin
    hit_d = qual & addr_eq;
    unique case (cfg_mode)
      MODE_INSIDE: begin
        hit_d[0] = qual[0] && in_win;
        hit_d[1] = 1'b0;
      end
      MODE_OUTSIDE: begin
        hit_d[0] = qual[0] && !in_win;
        hit_d[1] = 1'b0;
      end
      default: ;
    endcase
    if (!bus_valid) hit_d = '0;
    kind_d = hit_d & frc_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      force_q <= '0;
    end else begin
      match_q <= hit_d;
      force_q <= kind_d;
    end
  end

  assign match_o = match_q;
  assign force_o = force_q;
endmodule

// File: rtl/bcb_checker.sv
module bcb_checker
  import bcb_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           bus_valid,
  input logic                           bus_rd,
  input logic                           bus_word,
  input logic [ADDR_W-1:0]              bus_addr,
  input logic [2:0]                     match_o,
  input logic [2:0]                     force_o,
  input win_mode_e                      mode,
  input cmp_ctrl_t [NUM_CMP-1:0]        ctrl,
  input logic [NUM_CMP-1:0][ADDR_W-1:0] caddr
);
  logic unused_chk;
  assign unused_chk = ^{caddr[0], ctrl[0].dir_rd, ctrl[0].dir_en, ctrl[0].frc,
                        ctrl[0].sz_en, ctrl[0].sz_word, ctrl[1].frc,
                        ctrl[2].frc, ctrl[2].sz_en, ctrl[2].sz_word};

  logic win_mode;
  assign win_mode = (mode == MODE_INSIDE) || (mode == MODE_OUTSIDE);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> (match_o == 3'b000));

  p_force_needs_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (force_o & ~match_o) == 3'b000);

  p_b_quiet_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    win_mode |=> !match_o[1]);

  p_a_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[0].en |=> !match_o[0]);

  p_b_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[1].en |=> !match_o[1]);

  p_c_wrong_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && ctrl[2].en && ctrl[2].dir_en && (ctrl[2].dir_rd != bus_rd))
    |=> !match_o[2]);

  p_c_addr_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && ctrl[2].en && !ctrl[2].dir_en && (bus_addr == caddr[2]))
    |=> match_o[2]);

  p_b_size_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !win_mode && ctrl[1].en && !ctrl[1].dir_en && ctrl[1].sz_en &&
     (ctrl[1].sz_word == bus_word) && (bus_addr == caddr[1])) |=> match_o[1]);
endmodule

bind bus_cmp_bank bcb_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_valid(bus_valid),
  .bus_rd   (bus_rd),
  .bus_word (bus_word),
  .bus_addr (bus_addr),
  .match_o  (match_o),
  .force_o  (force_o),
  .mode     (cfg_mode),
  .ctrl     (ctrl),
  .caddr    (caddr)
);

// File: tb/bus_cmp_bank_test.sv
module bus_cmp_bank_test;
  localparam int  ADDR_W = 18;
  localparam int  DATA_W = 16;
  localparam time TCLK   = 10ns;

  logic              clk, rst_n, cfg_we, bus_valid, bus_rd, bus_word;
  logic [3:0]        cfg_sel;
  logic [ADDR_W-1:0] cfg_wdata, bus_addr;
  logic [DATA_W-1:0] bus_data;
  logic [2:0]        match_o, force_o;

  bus_cmp_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_rd(bus_rd), .bus_word(bus_word),
    .match_o(match_o), .force_o(force_o)
  );

  typedef struct {
    logic [2:0] m;
    logic [2:0] f;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 0;
  logic mon_v;

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  task automatic check(input string req, input logic [2:0] am, input logic [2:0] af,
                       input logic [2:0] em, input logic [2:0] ef);
    n_chk++;
    if (am !== em || af !== ef) begin
      n_fail++;
      $display("FAIL %s: match=%b force=%b expected match=%b force=%b", req, am, af, em, ef);
    end
  endtask

  // monitor: scores the result of every sampled edge
  always @(posedge clk) begin
    mon_v = bus_valid;
    #1;
    if (rst_n && !done) begin
      if (mon_v) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R2: result with no expected item");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(e.req, match_o, force_o, e.m, e.f);
        end
      end else begin
        check("R2 idle", match_o, force_o, 3'b000, 3'b000);
      end
    end
  end

  task automatic cfg(input logic [3:0] sel, input logic [ADDR_W-1:0] d);
    @(negedge clk);
    bus_valid = 1'b0;
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cyc(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                     input logic rd, input logic wd,
                     input logic [2:0] em, input logic [2:0] ef, input string req);
    exp_t e;
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a; bus_data = d; bus_rd = rd; bus_word = wd;
    e.m = em; e.f = ef; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    bus_valid = 1'b0; bus_addr = '0; bus_data = '0; bus_rd = 1'b0; bus_word = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R1 reset outputs", match_o, force_o, 3'b000, 3'b000);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state, address 0 equals every zero reference but all are off
    cyc(18'h00000, 16'h0000, 1'b1, 1'b1, 3'b000, 3'b000, "R1 disabled after reset");
    idle();

    // R3: comparator A, upper data byte compared
    cfg(4'd1, 18'h12345);
    cfg(4'd2, 18'h0A5C3);
    cfg(4'd3, 18'h0FF00);
    cfg(4'd0, 18'h00001);
    cyc(18'h12345, 16'hA511, 1'b0, 1'b1, 3'b001, 3'b000, "R3 masked data hit");
    cyc(18'h12345, 16'h5A11, 1'b0, 1'b1, 3'b000, 3'b000, "R3 masked data miss");
    cyc(18'h12346, 16'hA5C3, 1'b0, 1'b1, 3'b000, 3'b000, "R3 address miss");
    idle();

    // R9: force type on A
    cfg(4'd0, 18'h00009);
    cyc(18'h12345, 16'hA5FF, 1'b1, 1'b0, 3'b001, 3'b001, "R9 force typed");
    idle();

    // R4 / R5: B and C address only, C read-only
    cfg(4'd5, 18'h00400);
    cfg(4'd4, 18'h00001);
    cfg(4'd7, 18'h3FFFF);
    cfg(4'd6, 18'h00007);
    cyc(18'h00400, 16'hFFFF, 1'b0, 1'b0, 3'b010, 3'b000, "R4 B ignores data");
    cyc(18'h3FFFF, 16'h1234, 1'b1, 1'b1, 3'b100, 3'b000, "R5 C read hit");
    cyc(18'h3FFFF, 16'h1234, 1'b0, 1'b1, 3'b000, 3'b000, "R5 C write blocked");
    idle();

    // R6: size qualifier on B, ignored on A
    cfg(4'd4, 18'h00031);
    cyc(18'h00400, 16'h0000, 1'b1, 1'b1, 3'b010, 3'b000, "R6 B word hit");
    cyc(18'h00400, 16'h0000, 1'b1, 1'b0, 3'b000, 3'b000, "R6 B byte blocked");
    cfg(4'd0, 18'h00039);
    cyc(18'h12345, 16'hA500, 1'b0, 1'b0, 3'b001, 3'b001, "R6 size bits no effect on A");
    idle();

    // R10: disable A
    cfg(4'd0, 18'h00000);
    cyc(18'h12345, 16'hA5C3, 1'b0, 1'b1, 3'b000, 3'b000, "R10 A disabled");
    idle();

    // R7: inside window [0x100, 0x200]
    cfg(4'd1, 18'h00100);
    cfg(4'd3, 18'h00000);
    cfg(4'd0, 18'h00001);
    cfg(4'd5, 18'h00200);
    cfg(4'd4, 18'h00001);
    cfg(4'd8, 18'h00001);
    cyc(18'h00100, 16'h0000, 1'b0, 1'b1, 3'b001, 3'b000, "R7 low bound inclusive");
    cyc(18'h00200, 16'h0000, 1'b0, 1'b1, 3'b001, 3'b000, "R7 high bound inclusive, B quiet");
    cyc(18'h000FF, 16'h0000, 1'b0, 1'b1, 3'b000, 3'b000, "R7 below window");
    cyc(18'h00201, 16'h0000, 1'b0, 1'b1, 3'b000, 3'b000, "R7 above window");
    cyc(18'h00180, 16'h0000, 1'b0, 1'b1, 3'b001, 3'b000, "R7 mid window");
    idle();
    cfg(4'd0, 18'h0000B);  // en, dir qualify write-only, force
    cyc(18'h00180, 16'h0000, 1'b0, 1'b1, 3'b001, 3'b001, "R7 R9 window write force");
    cyc(18'h00180, 16'h0000, 1'b1, 1'b1, 3'b000, 3'b000, "R7 window read blocked");
    idle();
    cfg(4'd0, 18'h00001);

    // R8: outside window
    cfg(4'd8, 18'h00002);
    cyc(18'h000FF, 16'h0000, 1'b0, 1'b1, 3'b001, 3'b000, "R8 below is outside");
    cyc(18'h00201, 16'h0000, 1'b0, 1'b1, 3'b001, 3'b000, "R8 above is outside");
    cyc(18'h00100, 16'h0000, 1'b0, 1'b1, 3'b000, 3'b000, "R8 low bound not outside");
    cyc(18'h00200, 16'h0000, 1'b0, 1'b1, 3'b000, 3'b000, "R8 high bound not outside, B quiet");
    idle();

    // R11: mode 3 acts simple; unused selects change nothing
    cfg(4'd8, 18'h00003);
    cyc(18'h00200, 16'h0000, 1'b0, 1'b1, 3'b010, 3'b000, "R11 mode 3 simple B");
    cyc(18'h00180, 16'h0000, 1'b0, 1'b1, 3'b000, 3'b000, "R11 mode 3 no window");
    idle();
    cfg(4'd9,  18'h3FFFF);
    cfg(4'd15, 18'h00000);
    cyc(18'h00200, 16'h0000, 1'b0, 1'b1, 3'b010, 3'b000, "R11 unused select keeps B");
    cyc(18'h00100, 16'h0000, 1'b0, 1'b1, 3'b001, 3'b000, "R11 unused select keeps A");
    cyc(18'h3FFFF, 16'h0000, 1'b1, 1'b0, 3'b100, 3'b000, "R11 R2 unused select keeps C, back-to-back");
    idle();
    repeat (3) @(negedge clk);

    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2: %0d results missing, expected 0", exp_q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule